// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-lane SPI master attached to a 32-bit register port. Software sets the serial clock divisor, the clock polarity and phase, the bit order and the chip-select policy through registers. It then writes bytes into an 8-entry transmit queue. Each byte becomes one 8-bit frame on the wire. The byte clocked in from `miso` during the same frame lands in an 8-entry receive queue. Software drains that queue by reading the receive data register. Bit 31 of the two data registers reports transmit-full and receive-empty, so a driver polls the same address it moves data through.

The shift engine is a three-state machine. IDLE waits for a queued byte and for space in the receive queue. The transition IDLE→RUN pops the byte and asserts the frame. RUN steps through 16 half-periods of SCK, one per divider tick, sampling and shifting on alternate half-periods according to the phase bit. The transition RUN→TAIL happens on the tick that ends the last half-period. TAIL holds the chip select for one more half-period. The transition TAIL→IDLE pushes the received byte and ends the frame.

Chip selects are active relative to a per-line idle level. A line is driven to the inverse of its idle bit while it is asserted. Only the line picked by the select-index register can be asserted. The select-mode register decides whether that line follows each frame, stays asserted after a frame, or is never asserted.

Top module: `spi_master_ctl`

## Requirements
- R1: After reset the registers read: divisor (byte offset 0x00) 3, mode (0x04) 0, select index (0x10) 0, idle levels (0x14) all ones, select mode (0x18) 0, format (0x40) 0x0008_0000, transmit data (0x48) 0, receive data (0x4C) 0x8000_0000. `cs_n` is all ones and `sck` is 0.
- R2: Each SCK half-period, and the gap from chip-select assertion to the first SCK edge, lasts div+1 system clocks. The divisor is the low 12 bits of offset 0x00.
- R3: Offset 0x04 bit 1 is the SCK idle level (polarity) and bit 0 is the phase. With phase 0, data is valid before the first edge and sampled on odd-numbered edges. With phase 1, data changes on odd-numbered edges and is sampled on even-numbered edges. Every frame carries exactly 8 bits.
- R4: Format bit 2 set to 0 sends and receives MSB first. Set to 1, it sends and receives LSB first.
- R5: In select mode 0 (auto), `cs_n` equals the idle levels with only the line at the select index inverted. This holds from frame start until one half-period after the last SCK edge, and the line is released between frames.
- R6: In select mode 2 (hold), the selected line stays inverted after its frame ends. It is released when the select index, idle levels or select mode is written.
- R7: In select mode 3 (off), `cs_n` always equals the idle levels, while frames still transfer data.
- R8: A write to 0x48 queues bits 7:0 as one frame. A read of 0x48 returns bit 31 set while the transmit queue is full. A write made while the queue is full is discarded.
- R9: A read of 0x4C returns bit 31 set and pops nothing when the receive queue is empty. Otherwise it returns the oldest byte in bits 7:0 with bit 31 clear, and pops that byte.
- R10: Each queue holds 8 bytes and keeps first-in first-out order.
- R11: Every frame pushes its received byte. A frame never starts while the receive queue is full, so the transmit side stalls instead of losing data.
- R12: `req_ready` is always 1. A read returns its data with `rsp_valid` on the clock after it is accepted. The format register keeps bits 1:0, 2, 3 and 19:16 and reads zero elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | CS_LINES | Chip selects, relative to the idle levels |

## Verification
A phase counter that is off by one shows up on the wire at once. It yields a frame with a bit missing or duplicated, or a half-period of the wrong length, and the bench times each SCK toggle in system clocks during the frame. A wrong sample or shift choice corrupts the received byte. The bench loops `miso` back inverted, so the corruption surfaces at the first receive read. A chip-select state that fails to set or clear shows up in the `cs_n` pattern at frame start or at the tail edge. A queue pointer error shows up as lost, reordered or extra bytes in the overflow sequence.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RUN  = 2'd1,
        ENG_TAIL = 2'd2
    } eng_state_t;

    // word addresses (byte offset >> 2)
    localparam logic [5:0] WA_DIV    = 6'h00;
    localparam logic [5:0] WA_MODE   = 6'h01;
    localparam logic [5:0] WA_SEL    = 6'h04;
    localparam logic [5:0] WA_IDLE   = 6'h05;
    localparam logic [5:0] WA_SELMD  = 6'h06;
    localparam logic [5:0] WA_FMT    = 6'h10;
    localparam logic [5:0] WA_TXD    = 6'h12;
    localparam logic [5:0] WA_RXD    = 6'h13;

    localparam logic [1:0] SELMD_AUTO = 2'd0;
    localparam logic [1:0] SELMD_HOLD = 2'd2;
    localparam logic [1:0] SELMD_OFF  = 2'd3;

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wr_q, rd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (push) wr_q <= wr_q + 1'b1;
            if (pop)  rd_q <= rd_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_q[AW-1:0]] <= wdata;
    end

    assign rdata = mem[rd_q[AW-1:0]];
    assign empty = (wr_q == rd_q);
    assign full  = (wr_q[AW-1:0] == rd_q[AW-1:0]) && (wr_q[AW] != rd_q[AW]);

    // R8 / R11: a push never lands on a full queue
    a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R9: a pop never hits an empty queue
    a_r9_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/spi_shift_fsm.sv
module spi_shift_fsm import spi_ctl_pkg::*; #(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          lsb_first,
    input  logic          tx_valid,
    input  logic [FW-1:0] tx_byte,
    input  logic          rx_room,
    input  logic          miso,
    output logic          tx_pop,
    output logic          rx_push,
    output logic [FW-1:0] rx_byte,
    output logic          frame_active,
    output logic          sck,
    output logic          mosi
);
    localparam int PH_W = $clog2(2 * FW);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * FW - 1);

    eng_state_t state_q, state_d;
    logic [PH_W-1:0] ph_q;
    logic [FW-1:0]   tx_sr, rx_sr;
    logic            do_sample, do_shift;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENG_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE: if (tx_valid && rx_room)       state_d = ENG_RUN;
            ENG_RUN:  if (tick && ph_q == PH_LAST)   state_d = ENG_TAIL;
            ENG_TAIL: if (tick)                      state_d = ENG_IDLE;
            default:                                 state_d = ENG_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tx_pop       = (state_q == ENG_IDLE) && tx_valid && rx_room;
        rx_push      = (state_q == ENG_TAIL) && tick;
        frame_active = (state_q != ENG_IDLE);
        sck          = cpol ^ ((state_q == ENG_RUN) && ph_q[0]);
        mosi         = lsb_first ? tx_sr[0] : tx_sr[FW-1];
        rx_byte      = rx_sr;
        do_sample    = cpha ? ph_q[0] : !ph_q[0];
        do_shift     = cpha ? (!ph_q[0] && ph_q != '0) : (ph_q[0] && ph_q != PH_LAST);
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= '0;
            tx_sr <= '0;
            rx_sr <= '0;
        end else if (tx_pop) begin
            ph_q  <= '0;
            tx_sr <= tx_byte;
        end else if (state_q == ENG_RUN && tick) begin
            ph_q <= ph_q + 1'b1;
            if (do_sample)
                rx_sr <= lsb_first ? {miso, rx_sr[FW-1:1]} : {rx_sr[FW-2:0], miso};
            if (do_shift)
                tx_sr <= lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
        end
    end

    // R2: SCK moves only on a divider tick
    a_r2_sck_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ENG_IDLE && !tick) |=> ($stable(sck) || $changed(cpol)));
    // R11: the receive queue still has room when a frame completes
    a_r11_push_room: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> rx_room);

endmodule

// File: rtl/spi_master_ctl.sv
module spi_master_ctl import spi_ctl_pkg::*; #(
    parameter int CS_LINES   = 4,
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_W      = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [7:0]          req_addr,
    input  logic [31:0]         req_wdata,
    output logic                rsp_valid,
    output logic [31:0]         rsp_rdata,
    output logic                sck,
    output logic                mosi,
    input  logic                miso,
    output logic [CS_LINES-1:0] cs_n
);
    localparam int FW     = 8;
    localparam int CSID_W = (CS_LINES > 1) ? $clog2(CS_LINES) : 1;

    logic [DIV_W-1:0]    div_q;
    logic                cpol_q, cpha_q;
    logic [CSID_W-1:0]   sel_q;
    logic [CS_LINES-1:0] idle_q;
    logic [1:0]          selmd_q;
    logic [1:0]          proto_q;
    logic                lsb_q, dir_q;
    logic [3:0]          len_q;
    logic                hold_q;

    logic [5:0]  waddr;
    logic        wr_en, rd_en, tx_push, rx_pop, cs_touch;
    logic        tx_full, tx_empty, rx_full, rx_empty;
    logic [FW-1:0] tx_head, rx_head, rx_in;
    logic        tx_pop, rx_push, frame_active, tick, cs_on;
    logic [31:0] rd_word;

    assign req_ready = 1'b1;
    assign waddr     = req_addr[7:2];
    assign wr_en     = req_valid && req_write;
    assign rd_en     = req_valid && !req_write;
    assign tx_push   = wr_en && (waddr == WA_TXD) && !tx_full;
    assign rx_pop    = rd_en && (waddr == WA_RXD) && !rx_empty;
    assign cs_touch  = wr_en && (waddr == WA_SEL || waddr == WA_IDLE || waddr == WA_SELMD);

    // register file
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= DIV_W'(3);
            cpol_q  <= 1'b0;
            cpha_q  <= 1'b0;
            sel_q   <= '0;
            idle_q  <= '1;
            selmd_q <= SELMD_AUTO;
            proto_q <= 2'd0;
            lsb_q   <= 1'b0;
            dir_q   <= 1'b0;
            len_q   <= 4'd8;
        end else if (wr_en) begin
            case (waddr)
                WA_DIV:   div_q   <= req_wdata[DIV_W-1:0];
                WA_MODE:  {cpol_q, cpha_q} <= req_wdata[1:0];
                WA_SEL:   sel_q   <= req_wdata[CSID_W-1:0];
                WA_IDLE:  idle_q  <= req_wdata[CS_LINES-1:0];
                WA_SELMD: selmd_q <= req_wdata[1:0];
                WA_FMT: begin
                    proto_q <= req_wdata[1:0];
                    lsb_q   <= req_wdata[2];
                    dir_q   <= req_wdata[3];
                    len_q   <= req_wdata[19:16];
                end
                default: ;
            endcase
        end
    end

    // hold latch for the select line
    always_ff @(posedge clk) begin
        if (!rst_n || cs_touch)                    hold_q <= 1'b0;
        else if (tx_pop && selmd_q == SELMD_HOLD)  hold_q <= 1'b1;
    end

    always_comb begin
        case (selmd_q)
            SELMD_HOLD: cs_on = frame_active || hold_q;
            SELMD_OFF:  cs_on = 1'b0;
            default:    cs_on = frame_active;
        endcase
        cs_n = idle_q ^ (cs_on ? (CS_LINES'(1) << sel_q) : '0);
    end

    // read path
    always_comb begin
        case (waddr)
            WA_DIV:   rd_word = 32'(div_q);
            WA_MODE:  rd_word = {30'b0, cpol_q, cpha_q};
            WA_SEL:   rd_word = 32'(sel_q);
            WA_IDLE:  rd_word = 32'(idle_q);
            WA_SELMD: rd_word = {30'b0, selmd_q};
            WA_FMT:   rd_word = {12'b0, len_q, 12'b0, dir_q, lsb_q, proto_q};
            WA_TXD:   rd_word = {tx_full, 31'b0};
            WA_RXD:   rd_word = {rx_empty, 23'b0, rx_empty ? 8'h00 : rx_head};
            default:  rd_word = 32'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_en;
            if (rd_en) rsp_rdata <= rd_word;
        end
    end

    spi_byte_fifo #(.WIDTH(FW), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(req_wdata[FW-1:0]),
        .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty));

    spi_byte_fifo #(.WIDTH(FW), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_in),
        .pop(rx_pop), .rdata(rx_head), .full(rx_full), .empty(rx_empty));

    spi_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(frame_active), .div(div_q), .tick(tick));

    spi_shift_fsm #(.FW(FW)) u_eng (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cpol(cpol_q), .cpha(cpha_q),
        .lsb_first(lsb_q), .tx_valid(!tx_empty), .tx_byte(tx_head),
        .rx_room(!rx_full), .miso(miso), .tx_pop(tx_pop), .rx_push(rx_push),
        .rx_byte(rx_in), .frame_active(frame_active), .sck(sck), .mosi(mosi));

    // R5: never more than one line away from its idle level
    a_r5_single_line: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_n ^ idle_q));
    // R6: an asserted line in hold mode stays asserted unless select registers are written
    a_r6_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (selmd_q == SELMD_HOLD && $past(cs_n != idle_q) && !$past(cs_touch))
            |-> (cs_n != idle_q));
    // R7: off mode leaves every line at its idle level
    a_r7_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (selmd_q == SELMD_OFF) |-> (cs_n == idle_q));
    // R12: each read is answered on the next clock
    a_r12_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rsp_valid);

endmodule

// File: tb/test_spi_master_ctl.sv
module test_spi_master_ctl;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_DIV = 8'h00, A_MODE = 8'h04, A_SEL = 8'h10, A_IDLE = 8'h14,
                           A_SELMD = 8'h18, A_FMT = 8'h40, A_TX = 8'h48, A_RX = 8'h4C;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [7:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic req_ready, rsp_valid, sck, mosi, miso;
    logic [31:0] rsp_rdata;
    logic [3:0] cs_n;

    always #(CLK_PERIOD / 2) clk = ~clk;
    assign miso = ~mosi;

    spi_master_ctl i_spi_master_ctl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_n(cs_n));

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    // bench model of configuration
    logic [11:0] tb_div = 12'd3;
    logic tb_cpol = 0, tb_cpha = 0, tb_lsb = 0;
    logic [1:0] tb_sel = 0, tb_selmd = 0;
    logic [3:0] tb_idle = 4'hF;
    bit mon_en = 0, gap_en = 1, off_seen = 0;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] b);
        for (int i = 0; i < 8; i++) rev8[i] = b[7 - i];
    endfunction

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        d = rsp_rdata;
        if (rsp_valid !== 1'b1) check("R12 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    endtask

    task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
        mon_en = 0;
        bus_wr(a, d);
        case (a)
            A_DIV:   tb_div = d[11:0];
            A_MODE:  {tb_cpol, tb_cpha} = d[1:0];
            A_SEL:   tb_sel = d[1:0];
            A_IDLE:  tb_idle = d[3:0];
            A_SELMD: tb_selmd = d[1:0];
            A_FMT:   tb_lsb = d[2];
            default: ;
        endcase
        #1 mon_en = 1;
    endtask

    task automatic rx_wait(output logic [7:0] b);
        logic [31:0] d;
        bit got = 0;
        b = '0;
        for (int t = 0; t < 3000 && !got; t++) begin
            bus_rd(A_RX, d);
            if (!d[31]) begin got = 1; b = d[7:0]; end
        end
        if (!got) check("R11 rx timeout", 32'd0, 32'd1);
    endtask

    // wire capture on the sampling edge
    logic [7:0] wire_byte = '0;
    int wire_cnt = 0;
    always @(posedge sck or negedge sck) begin
        if (mon_en && cs_n !== tb_idle && sck === (tb_cpol == tb_cpha)) begin
            wire_byte = {wire_byte[6:0], mosi};
            wire_cnt++;
        end
    end

    // timing monitor, sampled on the falling clock edge
    logic last_sck = 0;
    bit last_act = 0;
    int gap = 0;
    always @(negedge clk) begin
        if (!mon_en) begin
            last_act = 0; last_sck = sck; gap = 0;
        end else begin
            bit act;
            act = (cs_n !== tb_idle);
            gap++;
            if (act && !last_act) begin
                gap = 0;
                if (tb_selmd == 2'd3) off_seen = 1;
                check("R5 cs pattern", {28'b0, cs_n}, {28'b0, tb_idle ^ (4'b1 << tb_sel)});
            end else if (act && gap_en && sck !== last_sck) begin
                check("R2 half period", gap, 32'(tb_div) + 1);
                gap = 0;
            end else if (!act && last_act && gap_en) begin
                check("R5 tail release", gap, 32'(tb_div) + 1);
            end
            last_act = act; last_sck = sck;
        end
    end

    task automatic send_byte(input logic [7:0] b);
        logic [7:0] r;
        wire_cnt = 0;
        bus_wr(A_TX, {24'b0, b});
        rx_wait(r);
        check("R11 rx byte", {24'b0, r}, {24'b0, ~b});
        if (tb_selmd != 2'd3) begin
            check("R4 wire order", {24'b0, wire_byte}, {24'b0, tb_lsb ? rev8(b) : b});
            check("R3 bit count", wire_cnt, 32'd8);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got hang expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0] r;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 cs_n", {28'b0, cs_n}, 32'hF);
        check("R1 sck", {31'b0, sck}, 32'd0);
        check("R12 ready", {31'b0, req_ready}, 32'd1);
        bus_rd(A_DIV, d);   check("R1 div", d, 32'd3);
        bus_rd(A_MODE, d);  check("R1 mode", d, 32'd0);
        bus_rd(A_SEL, d);   check("R1 sel", d, 32'd0);
        bus_rd(A_IDLE, d);  check("R1 idle", d, 32'hF);
        bus_rd(A_SELMD, d); check("R1 selmd", d, 32'd0);
        bus_rd(A_FMT, d);   check("R1 fmt", d, 32'h0008_0000);
        bus_rd(A_TX, d);    check("R1 tx", d, 32'd0);
        bus_rd(A_RX, d);    check("R9 rx empty", d, 32'h8000_0000);

        // R12 field masks, R2 divisor width
        bus_wr(A_FMT, 32'hFFFF_FFFF); bus_rd(A_FMT, d); check("R12 fmt mask", d, 32'h000F_000F);
        bus_wr(A_FMT, 32'h0008_0000);
        bus_wr(A_DIV, 32'hFFFF_FFFF); bus_rd(A_DIV, d); check("R2 div width", d, 32'h0000_0FFF);

        // sweep modes, bit orders and divisors in auto select mode
        cfg_wr(A_SEL, 32'd1);
        for (int dv = 0; dv < 2; dv++)
            for (int m = 0; m < 4; m++)
                for (int e = 0; e < 2; e++) begin
                    cfg_wr(A_DIV, dv * 3);
                    cfg_wr(A_MODE, m);
                    cfg_wr(A_FMT, 32'h0008_0000 | (e << 2));
                    @(negedge clk);
                    check("R3 idle level", {31'b0, sck}, {31'b0, tb_cpol});
                    send_byte(8'h5A ^ 8'(m * 37 + e * 11 + dv * 5));
                    send_byte(8'hC3 ^ 8'(m * 19 + e * 7 + dv));
                end

        // R5 custom idle levels
        cfg_wr(A_MODE, 0); cfg_wr(A_FMT, 32'h0008_0000); cfg_wr(A_DIV, 1);
        cfg_wr(A_IDLE, 32'h5); cfg_wr(A_SEL, 32'd2);
        send_byte(8'h96);
        @(negedge clk);
        check("R5 idle levels", {28'b0, cs_n}, 32'h5);
        cfg_wr(A_IDLE, 32'hF);

        // R6 hold mode
        gap_en = 0;
        cfg_wr(A_SELMD, 32'd2); cfg_wr(A_SEL, 32'd3);
        send_byte(8'h21);
        @(negedge clk);
        check("R6 held after frame", {28'b0, cs_n}, 32'h7);
        send_byte(8'hE4);
        repeat (10) @(negedge clk);
        check("R6 still held", {28'b0, cs_n}, 32'h7);
        cfg_wr(A_SEL, 32'd0);
        @(negedge clk);
        check("R6 released on write", {28'b0, cs_n}, 32'hF);

        // R7 off mode
        cfg_wr(A_SELMD, 32'd3);
        off_seen = 0;
        send_byte(8'h3C);
        check("R7 never asserted", {31'b0, off_seen}, 32'd0);
        check("R7 lines idle", {28'b0, cs_n}, 32'hF);

        // R8 / R10 / R11 queue depth and stall
        gap_en = 1;
        cfg_wr(A_SELMD, 32'd0); cfg_wr(A_DIV, 32'd0);
        for (int i = 0; i < 16; i++) begin
            d = 32'h8000_0000;
            for (int t = 0; t < 3000 && d[31]; t++) bus_rd(A_TX, d);
            bus_wr(A_TX, 32'h30 + i);
        end
        repeat (400) @(negedge clk);
        bus_rd(A_TX, d); check("R11 stalled tx full", d, 32'h8000_0000);
        bus_wr(A_TX, 32'hEE);
        for (int i = 0; i < 8; i++) begin
            bus_rd(A_RX, d);
            check("R10 rx order", d, {24'b0, ~(8'h30 + 8'(i))});
        end
        for (int i = 8; i < 16; i++) begin
            rx_wait(r);
            check("R10 tx order", {24'b0, r}, {24'b0, ~(8'h30 + 8'(i))});
        end
        repeat (400) @(negedge clk);
        bus_rd(A_RX, d); check("R8 full write dropped", d, 32'h8000_0000);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule